// File: doc/BRIEF.md
# Systematic Reed-Solomon (255,239) Encoder

This block is a streaming encoder for the full-length RS(255,239) code over GF(256). Each codeword starts with 239 message symbols, one per transfer. They arrive on a valid/ready byte port and leave unchanged on a valid/ready output port. Sixteen check symbols follow them. A division register produces the check symbols; it divides the message polynomial, multiplied by x^16, by the code generator.

Field arithmetic reduces products modulo x^8+x^4+x^3+x^2+1 (0x11D). The generator polynomial is the product of (x + alpha^i) for i from 0 to 15, where alpha is the primitive element 0x02. A constant function in the package computes the generator coefficients at elaboration, so the block needs no stored table. Framing flags mark the first and the last symbol of every codeword. The input port is closed while check symbols are being sent.

Top module: `rs_enc_top`

## Requirements
- R1: In every codeword, output symbols 0 to 238 are the accepted message bytes, in the order they arrived and with their values unchanged.
- R2: Output symbols 239 to 254 are the coefficients of the remainder of m(x)*x^16 divided by g(x), highest degree first. Here m(x) takes the first message byte as its x^238 coefficient.
- R3: Take the 255 output symbols as a polynomial with symbol 0 as the x^254 coefficient. This polynomial evaluates to zero at alpha^j for every j from 0 to 15.
- R4: During the 16 check-symbol beats, in_ready_o is 0 and out_valid_o is 1.
- R5: While out_valid_o is 1 and out_ready_i is 0 in the check phase, the next cycle shows the same symbol with out_valid_o still 1. Under any backpressure pattern, no output symbol is dropped and none is repeated.
- R6: out_sop_o is 1 only with symbol 0 of a codeword, and out_eop_o is 1 only with symbol 254. The symbol after symbol 254 is symbol 0 of the next codeword.
- R7: The division register is all zero when a new codeword starts. An all-zero message therefore yields 16 zero check symbols, whatever the codeword before it contained.
- R8: While rst_ni is low, and after it is released, the encoder waits for symbol 0: out_sop_o is 1, out_valid_o equals in_valid_i, and in_ready_o equals out_ready_i. This holds even when reset interrupts a codeword.
- R9: In the message phase, out_valid_o follows in_valid_i. A cycle without a transfer does not advance the position in the codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Message byte offered |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Encoder accepts a message byte |
| out_valid_o | output | 1 | Output symbol offered |
| out_data_o | output | 8 | Codeword symbol |
| out_sop_o | output | 1 | First symbol of the codeword |
| out_eop_o | output | 1 | Last symbol of the codeword |
| out_ready_i | input | 1 | Downstream accepts the symbol |

## Verification
The assertions assume that the upstream side offers message bytes only through in_valid_i/in_data_i, and that out_ready_i is a free-running level that needs no relation to out_valid_o. They also assume that reset is applied before the first clock edge. The stimulus draws in_valid_i and out_ready_i from $urandom with a fixed seed, at several densities. It changes them only at the falling edge, so every handshake is a clean level at the rising edge. The directed blocks are all zero, all 0xFF, a single nonzero final byte, and a reset in the middle of a codeword. They stay inside the same contract.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  parameter int SYM_W = 8;
  parameter logic [SYM_W:0] FIELD_POLY = 9'h11D;
  parameter int MAX_PAR = 32;

  function automatic logic [SYM_W-1:0] gf_mul(logic [SYM_W-1:0] a, logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ aa;
      aa = aa[SYM_W-1] ? ((aa << 1) ^ FIELD_POLY[SYM_W-1:0]) : (aa << 1);
    end
    return p;
  endfunction

  // generator coefficients, index = power of x, roots alpha^fcr .. alpha^(fcr+npar-1)
  function automatic logic [MAX_PAR:0][SYM_W-1:0] gen_poly(int npar, int fcr);
    logic [MAX_PAR:0][SYM_W-1:0] g;
    logic [SYM_W-1:0] root;
    g    = '0;
    g[0] = 1;
    root = 1;
    for (int k = 0; k < fcr; k++) root = gf_mul(root, 2);
    for (int i = 0; i < npar; i++) begin
      for (int j = MAX_PAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 2);
    end
    return g;
  endfunction
endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int N_SYM = 255,
  parameter int K_SYM = 239
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic check_ph_o,
  output logic sop_o,
  output logic eop_o
);
  localparam int CW = $clog2(N_SYM);

  logic [CW-1:0] pos_q;

  assign sop_o      = (pos_q == '0);
  assign eop_o      = (pos_q == CW'(N_SYM - 1));
  assign check_ph_o = (pos_q >= CW'(K_SYM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= eop_o ? '0 : pos_q + 1'b1;
  end

  assert_pos_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < CW'(N_SYM));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 16,
  parameter int FCR  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             drain_i,
  input  logic [SYM_W-1:0] din_i,
  output logic [SYM_W-1:0] top_o,
  output logic             zero_o
);
  localparam logic [MAX_PAR:0][SYM_W-1:0] GEN = gen_poly(NPAR, FCR);

  logic [SYM_W-1:0] rem_q [NPAR];
  logic [SYM_W-1:0] fb;

  assign top_o = rem_q[NPAR-1];
  // feedback is zero while draining, so the register just shifts out
  assign fb = drain_i ? '0 : (din_i ^ rem_q[NPAR-1]);

  always_comb begin
    zero_o = 1'b1;
    for (int i = 0; i < NPAR; i++) if (rem_q[i] != '0) zero_o = 1'b0;
  end

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    logic [SYM_W-1:0] prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = rem_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rem_q[i] <= '0;
      else if (en_i) rem_q[i] <= prev ^ gf_mul(fb, GEN[i]);
    end
  end
endmodule

// File: rtl/rs_enc_top.sv
module rs_enc_top
  import rs_enc_pkg::*;
#(
  parameter int N_SYM = 255,
  parameter int K_SYM = 239,
  parameter int FCR   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SYM_W-1:0] in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_sop_o,
  output logic             out_eop_o,
  input  logic             out_ready_i
);
  localparam int NPAR = N_SYM - K_SYM;

  logic check_ph, step, rem_zero;
  logic [SYM_W-1:0] rem_top;

  assign out_valid_o = check_ph | in_valid_i;
  assign in_ready_o  = ~check_ph & out_ready_i;
  assign out_data_o  = check_ph ? rem_top : in_data_i;
  assign step        = out_valid_o & out_ready_i;

  rs_enc_ctrl #(.N_SYM(N_SYM), .K_SYM(K_SYM)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .check_ph_o (check_ph),
    .sop_o      (out_sop_o),
    .eop_o      (out_eop_o)
  );

  rs_enc_lfsr #(.NPAR(NPAR), .FCR(FCR)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (step),
    .drain_i (check_ph),
    .din_i   (in_data_i),
    .top_o   (rem_top),
    .zero_o  (rem_zero)
  );

  assert_hold_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && check_ph) |=> (out_valid_o && $stable(out_data_o)));
  assert_clear_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && out_eop_o) |=> rem_zero);
  assert_wrap_sop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && out_eop_o) |=> out_sop_o);
  assert_flags_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_sop_o, out_eop_o}));
endmodule

// File: tb/sim_rs_enc_top.sv
`timescale 1ns/1ps
module sim_rs_enc_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  rs_enc_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_sop_o(out_sop), .out_eop_o(out_eop), .out_ready_i(out_ready)
  );

  int n_vec = 0, n_err = 0;
  logic [7:0] msg [239];
  logic [7:0] cw  [255];
  logic [7:0] rx  [255];
  logic [7:0] gp  [17];

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] apow(int e);
    logic [7:0] r = 1;
    for (int i = 0; i < e; i++) r = gmul(r, 8'h02);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_gen();
    for (int j = 0; j < 17; j++) gp[j] = 0;
    gp[0] = 1;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] rt = apow(i);
      for (int j = 16; j > 0; j--) gp[j] = gp[j-1] ^ gmul(gp[j], rt);
      gp[0] = gmul(gp[0], rt);
    end
  endtask

  // long division: index 0 is the highest power
  task automatic build_cw();
    logic [7:0] r [255];
    for (int i = 0; i < 255; i++) r[i] = (i < 239) ? msg[i] : 8'h00;
    for (int i = 0; i < 239; i++) begin
      logic [7:0] c = r[i];
      if (c != 0) for (int j = 0; j <= 16; j++) r[i+j] = r[i+j] ^ gmul(c, gp[16-j]);
    end
    for (int i = 0; i < 255; i++) cw[i] = (i < 239) ? msg[i] : r[i];
  endtask

  task automatic run_block(int vld_pct, int rdy_pct);
    int pos = 0, idx = 0;
    bit stalled = 0;
    logic [7:0] held = 0;
    build_cw();
    while (pos < 255) begin
      @(negedge clk);
      in_valid  = (idx < 239) && (($urandom % 100) < vld_pct);
      in_data   = msg[(idx < 239) ? idx : 0];
      out_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (pos < 239) chk(out_valid == in_valid, "R9", out_valid, in_valid);
      else begin
        chk(!in_ready && out_valid, "R4", {in_ready, out_valid}, 1);
        if (stalled) chk(out_data == held, "R5", out_data, held);
      end
      stalled = out_valid && !out_ready && (pos >= 239);
      held    = out_data;
      if (out_valid && out_ready) begin
        chk(out_data == cw[pos], (pos < 239) ? "R1" : "R2", out_data, cw[pos]);
        chk(out_sop == (pos == 0) && out_eop == (pos == 254), "R6",
            {out_sop, out_eop}, {pos == 0, pos == 254});
        rx[pos] = out_data;
        pos++;
      end
      if (in_valid && in_ready) idx++;
    end
    for (int j = 0; j < 16; j++) begin
      logic [7:0] s = 0, a = apow(j);
      for (int k = 0; k < 255; k++) s = gmul(s, a) ^ rx[k];
      chk(s == 0, "R3", s, 0);
    end
  endtask

  task automatic reset_state_check();
    @(negedge clk);
    in_valid = 0; out_ready = 1; #1;
    chk(out_sop && !out_valid && in_ready, "R8", {out_sop, out_valid, in_ready}, 3'b101);
    out_ready = 0; #1;
    chk(!in_ready, "R8", in_ready, 0);
  endtask

  initial begin
    #(64'd200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    build_gen();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    reset_state_check();
    for (int i = 0; i < 239; i++) msg[i] = 8'($urandom);
    run_block(100, 100);
    for (int i = 0; i < 239; i++) msg[i] = 8'($urandom);
    run_block(70, 60);
    // R7: zero message after nonzero block must give zero parity
    for (int i = 0; i < 239; i++) msg[i] = 8'h00;
    run_block(80, 50);
    for (int i = 0; i < 239; i++) msg[i] = 8'hFF;
    run_block(90, 30);
    for (int i = 0; i < 239; i++) msg[i] = (i == 238) ? 8'h01 : 8'h00;
    run_block(100, 80);
    // R8: reset in the middle of a codeword
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'($urandom); out_ready = 1;
    end
    @(negedge clk);
    in_valid = 0; rst_ni = 0;
    #1 chk(out_sop && !out_valid, "R8", {out_sop, out_valid}, 2'b10);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    reset_state_check();
    for (int i = 0; i < 239; i++) msg[i] = 8'($urandom);
    run_block(60, 70);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule